// File: doc/BRIEF.md
# BCD Clock-Calendar Register Bank

This block keeps time of day and calendar date in packed BCD, from hundredths of a second up to a two-digit year. Hours run in 24-hour form, and month lengths, including February 29 in leap years, are handled without software help. A set of internal counters advances on a single-cycle tick input, with one tick for each hundredth of a second. Software never reads these counters directly. It reads a second, user-visible copy of them, which sits in the top sixteen bytes of a byte-wide address space and is reached through a simple synchronous RAM-style port.

Once per second, at the moment the hundredths counter wraps, the whole user copy is refreshed from the counters in one step. Two freeze bits in a control register block this refresh. A read freeze gives software a stable snapshot while the counters keep running. A write freeze lets software compose a new time in the user copy. Clearing the write freeze moves those values into the counters. A stop bit in the seconds register halts timekeeping, and this bit is set after reset.

Top module: `rtc_bank`

## Requirements
- R1: After reset, every time register reads its lowest legal value: hundredths, seconds, minutes, hours and year read 0x00, and weekday, date and month read 0x01. The seconds register reads 0x80 because the stop bit is set. The control register reads 0x00.
- R2: While the stop bit is 0, each tick advances the hundredths counter. On the tick that wraps hundredths from 99 to 00, all user registers take the new counter values at that same clock edge. The user hundredths therefore reads 00 after a refresh.
- R3: Carries ripple in this order: hundredths, seconds, minutes, hours, then date and weekday together, then month, then year. Seconds and minutes wrap 59 to 00, hours wrap 23 to 00, weekday wraps 7 to 1, month wraps 12 to 01, and year wraps 99 to 00.
- R4: The last date of a month is 28 for February in a year not divisible by 4, 29 for February in a year divisible by 4 (00 included), 30 for months 04, 06, 09 and 11, and 31 for all other months.
- R5: Control bit 6 is the read freeze. While it is 1, the user registers keep their values and the internal counters keep counting. After it is cleared, the next one-second boundary shows the true time.
- R6: Control bit 7 is the write freeze. While it is 1, no refresh happens and register writes are kept. A control write with bit 7 equal to 0 while the write freeze is set loads all eight user values into the counters at that edge, and counting continues from them.
- R7: A control write that sets a freeze bit in the same cycle as a one-second boundary does not cancel that refresh. The refresh completes and the freeze applies from then on.
- R8: Bit 7 of the seconds register (offset 1) is the stop bit. While it is 1, ticks are ignored and the counters hold. It is written by any write to the seconds register.
- R9: Bits with no function read back as 0, and writing them has no effect. Field widths in bits are: hundredths 8, seconds 7, minutes 7, hours 6, weekday 3, date 6, month 5, year 8. Only control bits 7 and 6 are used. Offsets 9 to 15 read 0, and accesses outside the top sixteen bytes are ignored and read 0.
- R10: The map inside the window is: offset 0 hundredths, 1 seconds, 2 minutes, 3 hours, 4 weekday, 5 date, 6 month, 7 year, 8 control. Read data is registered and appears in the cycle after a read access with chip select high and write enable low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One pulse per hundredth of a second |
| cs | input | 1 | Access select |
| we | input | 1 | Write when 1, read when 0 |
| addr | input | ADDR_W (13) | Byte address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |

## Verification
A one-second refresh and a control write that raises a freeze bit can land on the same clock edge. The bench sets up this collision by loading a time ending in .99 and then driving the single wrapping tick and the control write in the same cycle. The result is judged correct only if the seconds register shows the incremented value, the control register shows the freeze set, and the seconds value then stays fixed over a further full second of ticks. A second collision also occurs: a load of the counters on write-freeze release and a refresh at the next tick. The bench resolves it by reading the wrapped calendar fields right after that tick.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int NFIELD = 8;
  typedef logic [7:0] bcd_t;
  typedef logic [NFIELD-1:0][7:0] bank_t;

  localparam int F_HUND  = 0;
  localparam int F_SEC   = 1;
  localparam int F_MIN   = 2;
  localparam int F_HOUR  = 3;
  localparam int F_WDAY  = 4;
  localparam int F_DATE  = 5;
  localparam int F_MONTH = 6;
  localparam int F_YEAR  = 7;

  function automatic bcd_t field_mask(input int i);
    case (i)
      F_SEC, F_MIN: return 8'h7F;
      F_HOUR, F_DATE: return 8'h3F;
      F_WDAY: return 8'h07;
      F_MONTH: return 8'h1F;
      default: return 8'hFF;
    endcase
  endfunction

  function automatic bcd_t field_lo(input int i);
    return (i == F_WDAY || i == F_DATE || i == F_MONTH) ? 8'h01 : 8'h00;
  endfunction

  function automatic bcd_t field_hi(input int i);
    case (i)
      F_SEC, F_MIN: return 8'h59;
      F_HOUR: return 8'h23;
      F_WDAY: return 8'h07;
      F_DATE: return 8'h31;
      F_MONTH: return 8'h12;
      default: return 8'h99;
    endcase
  endfunction

  // field whose wrap advances field i (weekday and date share the hour carry)
  function automatic int carry_src(input int i);
    return (i == F_DATE) ? F_HOUR : i - 1;
  endfunction

  function automatic logic is_leap(input bcd_t yr);
    if (!yr[4]) return (yr[3:0] == 4'd0) || (yr[3:0] == 4'd4) || (yr[3:0] == 4'd8);
    else        return (yr[3:0] == 4'd2) || (yr[3:0] == 4'd6);
  endfunction

  function automatic bcd_t month_days(input bcd_t mo, input bcd_t yr);
    case (mo)
      8'h02: return is_leap(yr) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default: return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_bcd_field.sv
module rtc_bcd_field (
  input  logic       en,
  input  logic [7:0] val,
  input  logic [7:0] lo,
  input  logic [7:0] hi,
  output logic [7:0] nxt,
  output logic       wrap
);
  logic       at_top;
  logic [7:0] inc;

  always_comb begin
    // >= rather than == so an out-of-range loaded value still wraps
    at_top = (val >= hi);
    if (val[3:0] >= 4'd9) inc = {val[7:4] + 4'd1, 4'd0};
    else                  inc = val + 8'd1;
    wrap = en && at_top;
    if (!en)        nxt = val;
    else if (at_top) nxt = lo;
    else            nxt = inc;
  end
endmodule

// File: rtl/rtc_time_chain.sv
module rtc_time_chain
  import rtc_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  adv,
  input  logic  load,
  input  bank_t load_val,
  output bank_t cur,
  output bank_t nxt,
  output logic  sec_roll
);
  bank_t              cnt_q, cnt_d;
  logic [NFIELD-1:0]  en, wrap;
  bank_t              hi;

  for (genvar i = 0; i < NFIELD; i++) begin : g_field
    if (i == 0) begin : g_first
      assign en[i] = adv;
    end else begin : g_rest
      assign en[i] = wrap[carry_src(i)];
    end
    if (i == F_DATE) begin : g_date
      assign hi[i] = month_days(cnt_q[F_MONTH], cnt_q[F_YEAR]);
    end else begin : g_fixed
      assign hi[i] = field_hi(i);
    end
    rtc_bcd_field u_fld (
      .en   (en[i]),
      .val  (cnt_q[i]),
      .lo   (field_lo(i)),
      .hi   (hi[i]),
      .nxt  (nxt[i]),
      .wrap (wrap[i])
    );
  end

  always_comb begin
    cnt_d = load ? load_val : nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NFIELD; i++) cnt_q[i] <= field_lo(i);
    end else if (load || adv) begin
      cnt_q <= cnt_d;
    end
  end

  assign cur      = cnt_q;
  assign sec_roll = wrap[F_HUND] && !load;

  // R8: without a tick (or a load) the counters never move
  p_hold_stopped_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !load) |=> $stable(cnt_q));
  // R6: a load lands in the counters on the next edge
  p_load_lands_r6: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_q == $past(load_val)));
  // R2: a second boundary leaves hundredths at zero
  p_roll_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sec_roll |=> (cnt_q[F_HUND] == 8'h00));
endmodule

// File: rtl/rtc_bank.sv
module rtc_bank
  import rtc_pkg::*;
#(
  parameter int ADDR_W   = 13,
  parameter int WIN_BITS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              cs,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata
);
  localparam logic [WIN_BITS-1:0] CTL_OFF = WIN_BITS'(NFIELD);

  logic [1:0] rs_q;
  logic       rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_s = rs_q[1];

  logic                in_win, wr_acc, rd_acc, ctl_wr_acc;
  logic [WIN_BITS-1:0] off;
  assign in_win     = &addr[ADDR_W-1:WIN_BITS];
  assign off        = addr[WIN_BITS-1:0];
  assign wr_acc     = cs && we && in_win;
  assign rd_acc     = cs && !we;
  assign ctl_wr_acc = wr_acc && (off == CTL_OFF);

  bank_t u_q, u_d, cnt, nxt;
  logic  osc_q, osc_d, frz_rd_q, frz_rd_d, frz_wr_q, frz_wr_d;
  logic  frozen, load, adv, roll;
  logic [7:0] rdata_q, rdata_d;

  assign frozen = frz_rd_q || frz_wr_q;
  assign load   = ctl_wr_acc && frz_wr_q && !wdata[7];
  assign adv    = tick && !osc_q;

  rtc_time_chain u_chain (
    .clk      (clk),
    .rst_n    (rst_s),
    .adv      (adv),
    .load     (load),
    .load_val (u_q),
    .cur      (cnt),
    .nxt      (nxt),
    .sec_roll (roll)
  );

  always_comb begin
    for (int i = 0; i < NFIELD; i++) begin
      u_d[i] = u_q[i];
      // freeze state sampled before this cycle's write: a refresh in flight completes
      if (roll && !frozen) u_d[i] = nxt[i] & field_mask(i);
      if (wr_acc && (off == WIN_BITS'(i))) u_d[i] = wdata & field_mask(i);
    end
    osc_d    = (wr_acc && off == WIN_BITS'(F_SEC)) ? wdata[7] : osc_q;
    frz_wr_d = ctl_wr_acc ? wdata[7] : frz_wr_q;
    frz_rd_d = ctl_wr_acc ? wdata[6] : frz_rd_q;
  end

  always_comb begin
    rdata_d = rdata_q;
    if (rd_acc) begin
      rdata_d = 8'h00;
      if (in_win) begin
        for (int i = 0; i < NFIELD; i++)
          if (off == WIN_BITS'(i)) rdata_d = u_q[i];
        if (off == WIN_BITS'(F_SEC)) rdata_d[7] = osc_q;
        if (off == CTL_OFF) rdata_d = {frz_wr_q, frz_rd_q, 6'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      for (int i = 0; i < NFIELD; i++) u_q[i] <= field_lo(i);
      osc_q    <= 1'b1;
      frz_rd_q <= 1'b0;
      frz_wr_q <= 1'b0;
      rdata_q  <= 8'h00;
    end else begin
      u_q      <= u_d;
      osc_q    <= osc_d;
      frz_rd_q <= frz_rd_d;
      frz_wr_q <= frz_wr_d;
      rdata_q  <= rdata_d;
    end
  end

  assign rdata = rdata_q;

  // R5: while frozen and untouched by software, the user copy holds
  p_freeze_hold_r5: assert property (@(posedge clk) disable iff (!rst_s)
    (frozen && !wr_acc) |=> $stable(u_q));
  // R2: an unfrozen boundary makes the user copy match the counters
  p_copy_match_r2: assert property (@(posedge clk) disable iff (!rst_s)
    (roll && !frozen && !wr_acc) |=> (u_q == cnt));
  // R7: raising a freeze on a boundary still lets that refresh through
  p_same_cycle_r7: assert property (@(posedge clk) disable iff (!rst_s)
    (roll && !frozen && ctl_wr_acc) |=> (u_q[F_SEC] == cnt[F_SEC]) && frozen);
endmodule

// File: tb/rtc_bank_bench.sv
module rtc_bank_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0, cs = 1'b0, we = 1'b0;
  logic [12:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;

  int checks = 0, fails = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic       rd_launch = 1'b0;
  bit         done = 1'b0;

  localparam logic [12:0] BASE = 13'h1FF0;

  always #10 clk = ~clk;

  rtc_bank u_rtc_bank (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cs(cs), .we(we),
    .addr(addr), .wdata(wdata), .rdata(rdata)
  );

  // monitor: pops one expectation per completed read
  always @(posedge clk) rd_launch <= cs && !we;
  always @(negedge clk) begin
    if (rd_launch && exp_q.size() > 0) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (rdata !== e) begin
        fails++;
        $display("FAIL %s: got %02h expected %02h", t, rdata, e);
      end
    end
  end

  task automatic wr(input logic [12:0] a, input logic [7:0] d);
    @(negedge clk); cs = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); cs = 0; we = 0;
  endtask

  task automatic rd(input logic [12:0] a, input logic [7:0] e, input string t);
    @(negedge clk); cs = 1; we = 0; addr = a;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk); cs = 0;
  endtask

  task automatic tick_n(input int n);
    @(negedge clk); tick = 1;
    repeat (n) @(negedge clk);
    tick = 0;
  endtask

  task automatic set_time(input logic [7:0] h, s, m, hr, wd, dt, mo, yr);
    wr(BASE + 8, 8'h80);
    wr(BASE + 0, h);  wr(BASE + 1, s);  wr(BASE + 2, m);  wr(BASE + 3, hr);
    wr(BASE + 4, wd); wr(BASE + 5, dt); wr(BASE + 6, mo); wr(BASE + 7, yr);
    wr(BASE + 8, 8'h00);   // R6: releasing the write freeze loads the counters
  endtask

  task automatic finish_run();
    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1 / R10 reset values and map
    rd(BASE + 0, 8'h00, "R1 hundredths");
    rd(BASE + 1, 8'h80, "R1 seconds with stop bit");
    rd(BASE + 3, 8'h00, "R1 hours");
    rd(BASE + 4, 8'h01, "R1 weekday");
    rd(BASE + 5, 8'h01, "R1 date");
    rd(BASE + 6, 8'h01, "R10 month offset 6");
    rd(BASE + 8, 8'h00, "R1 control");

    // R8: ticks ignored while stopped, then start the clock
    tick_n(150);
    rd(BASE + 1, 8'h80, "R8 seconds held while stopped");
    wr(BASE + 1, 8'h00);
    tick_n(100);
    rd(BASE + 1, 8'h01, "R8 R2 one second after start");
    rd(BASE + 0, 8'h00, "R2 hundredths after refresh");

    // R3 / R4 rollovers
    set_time(8'h99, 8'h59, 8'h59, 8'h23, 8'h07, 8'h28, 8'h02, 8'h23);
    tick_n(1);
    rd(BASE + 1, 8'h00, "R3 seconds wrap");
    rd(BASE + 2, 8'h00, "R3 minutes wrap");
    rd(BASE + 3, 8'h00, "R3 hours wrap at 23");
    rd(BASE + 4, 8'h01, "R3 weekday 7 to 1");
    rd(BASE + 5, 8'h01, "R4 Feb 28 non-leap");
    rd(BASE + 6, 8'h03, "R4 month to March");

    set_time(8'h99, 8'h59, 8'h59, 8'h23, 8'h02, 8'h28, 8'h02, 8'h00);
    tick_n(1);
    rd(BASE + 5, 8'h29, "R4 Feb 29 in year 00");
    rd(BASE + 4, 8'h03, "R3 weekday step");

    set_time(8'h99, 8'h59, 8'h59, 8'h23, 8'h01, 8'h29, 8'h02, 8'h24);
    tick_n(1);
    rd(BASE + 5, 8'h01, "R4 leap Feb 29 to 01");
    rd(BASE + 6, 8'h03, "R4 leap month to March");

    set_time(8'h99, 8'h59, 8'h59, 8'h23, 8'h01, 8'h30, 8'h04, 8'h15);
    tick_n(1);
    rd(BASE + 5, 8'h01, "R4 thirty-day month");
    rd(BASE + 6, 8'h05, "R4 April to May");

    set_time(8'h99, 8'h59, 8'h59, 8'h23, 8'h05, 8'h31, 8'h12, 8'h99);
    tick_n(1);
    rd(BASE + 6, 8'h01, "R3 month 12 to 01");
    rd(BASE + 7, 8'h00, "R3 year 99 to 00");
    rd(BASE + 5, 8'h01, "R4 Dec 31 to 01");

    // R5 read freeze
    set_time(8'h00, 8'h00, 8'h00, 8'h10, 8'h01, 8'h01, 8'h01, 8'h10);
    tick_n(100);
    rd(BASE + 1, 8'h01, "R5 before freeze");
    wr(BASE + 8, 8'h40);
    tick_n(200);
    rd(BASE + 1, 8'h01, "R5 seconds frozen");
    rd(BASE + 8, 8'h40, "R5 control shows read freeze");
    wr(BASE + 8, 8'h00);
    tick_n(100);
    rd(BASE + 1, 8'h04, "R5 counters kept running");

    // R6 write freeze blocks refresh
    wr(BASE + 8, 8'h80);
    tick_n(100);
    rd(BASE + 1, 8'h04, "R6 no refresh under write freeze");

    // R7 freeze raised on the boundary edge
    set_time(8'h99, 8'h10, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00);
    @(negedge clk);
    tick = 1; cs = 1; we = 1; addr = BASE + 8; wdata = 8'h40;
    @(negedge clk);
    tick = 0; cs = 0; we = 0;
    rd(BASE + 1, 8'h11, "R7 refresh completed");
    rd(BASE + 8, 8'h40, "R7 freeze applied");
    tick_n(100);
    rd(BASE + 1, 8'h11, "R7 frozen after boundary");
    wr(BASE + 8, 8'h00);
    tick_n(100);
    rd(BASE + 1, 8'h13, "R7 resumes after release");

    // R9 unused bits, empty offsets, outside window
    wr(BASE + 8, 8'h80);
    wr(BASE + 3, 8'hFF);
    rd(BASE + 3, 8'h3F, "R9 hours unused bits");
    wr(BASE + 4, 8'hFF);
    rd(BASE + 4, 8'h07, "R9 weekday unused bits");
    wr(BASE + 8, 8'hFF);
    rd(BASE + 8, 8'hC0, "R9 control unused bits");
    wr(BASE + 2, 8'h42);
    wr(BASE + 10, 8'h55);
    rd(BASE + 10, 8'h00, "R9 empty offset");
    wr(13'h0FF2, 8'h17);
    rd(BASE + 2, 8'h42, "R9 outside write ignored");
    rd(13'h0FF2, 8'h00, "R9 outside read zero");

    wait (exp_q.size() == 0);
    done = 1;
    finish_run();
  end
endmodule